// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This controller sits on the digital side of an external dual-slope integrating front end. On each accepted start it walks the front end through its four phases by driving a 2-bit phase code: auto-zero, signal integrate, deintegrate and integrator zero. It latches the input polarity from the comparator level at the end of integration. It then measures how many system clock cycles the integrator takes to return to its starting level against the reference, and that count is the converted magnitude.

The comparator is asynchronous to the system clock, so it is passed through a two-flop synchronizer before any decision uses it. Its level is ignored while auto-zero runs. Right after deintegrate begins, the comparator is blanked for a programmable number of cycles to cover its response lag. A run-time maximum count bounds deintegrate and flags an overrange. Integrator zero ends once the comparator has held one level for a set number of cycles, not after a fixed time.

A 2-bit channel code for a four-channel differential multiplexer is captured at start and held for the whole conversion. Phase durations are parameters in system clock cycles. With the default 200 MHz clock, the auto-zero and integrate defaults each equal 66 ms.

Top module: `dslope_seq`

## Requirements
- R1: An accepted start gives phase_ab = 01 (auto-zero) for exactly AZ_CYC cycles, then 10 (integrate) for exactly INT_CYC cycles, then 11 (deintegrate), then 00 (integrator zero), and then back to idle, where the code stays 00.
- R2: After reset: busy=0, done=0, phase_ab=00, res_mag=0, res_ovr=0 and chan_sel=00. A start is accepted only while busy is low, and a start pulse while busy has no effect on phase timing or on the result.
- R3: chan_sel takes the value of chan_req on the accepted start cycle (00, 01, 10, 11 select channels 1 to 4). It then holds that value until the next accepted start, whatever chan_req does.
- R4: The comparator level during auto-zero has no effect on the sign, the magnitude or the phase timing.
- R5: res_sign is 0 when the synchronized comparator was high on the last integrate cycle (positive input), and 1 when it was low (negative input).
- R6: Deintegrate runs until the synchronized comparator differs from the level latched at the end of integrate. If the raw comparator changes at the falling edge in deintegrate cycle K (cycle 0 being the first cycle with code 11), then res_mag = max(K+2, BLANK_CYC) when that value is no larger than deint_max.
- R7: No comparator change is accepted while the deintegrate count is below BLANK_CYC. A completed non-overrange result is always at least BLANK_CYC.
- R8: If the count reaches deint_max without an accepted change, res_ovr=1 and res_mag=deint_max, and integrator zero follows. Deintegrate therefore lasts res_mag+1 cycles in every case.
- R9: Integrator zero lasts SETTLE_CYC cycles when the comparator is steady. If the raw comparator toggles at integrator-zero cycle g (with -2 <= g <= SETTLE_CYC-3), the phase lasts g+3+SETTLE_CYC cycles.
- R10: done is high for exactly one cycle, the first idle cycle after integrator zero. res_sign, res_mag and res_ovr then hold until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Conversion request, sampled while idle |
| chan_req | input | 2 | Requested multiplexer channel |
| deint_max | input | CNT_W | Overrange limit for the deintegrate count |
| cmp_async | input | 1 | Raw zero-crossing comparator output |
| phase_ab | output | 2 | Phase code to the front end |
| chan_sel | output | 2 | Held multiplexer channel code |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle completion pulse |
| res_sign | output | 1 | 1 for a negative input |
| res_mag | output | CNT_W | Deintegrate count |
| res_ovr | output | 1 | Overrange flag |

## Verification
The bench sweeps the comparator crossing across every deintegrate cycle, for both polarities and for three overrange limits. This covers crossings inside the blanking window, which a design without blanking would report too short. It also covers crossings on the very cycle the limit is reached, where a wrong priority would raise overrange for a valid result. A late crossing can spill past an overrange exit into integrator zero, and toggles are also injected there on purpose; a design that timed this phase with a fixed count would end it early. Comparator noise during auto-zero, a channel request that changes mid-conversion and a start pulse while busy expose designs that sample the comparator too early, track chan_req, or restart.

// File: rtl/dslope_pkg.sv
package dslope_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_AZ,
    ST_INTG,
    ST_DEINT,
    ST_IZ
  } seq_state_e;

  localparam logic [1:0] PH_IZ    = 2'b00;
  localparam logic [1:0] PH_AZ    = 2'b01;
  localparam logic [1:0] PH_INTG  = 2'b10;
  localparam logic [1:0] PH_DEINT = 2'b11;

  function automatic logic [1:0] phase_code(input seq_state_e st);
    case (st)
      ST_AZ:    phase_code = PH_AZ;
      ST_INTG:  phase_code = PH_INTG;
      ST_DEINT: phase_code = PH_DEINT;
      default:  phase_code = PH_IZ;
    endcase
  endfunction
endpackage

// File: rtl/dslope_sync.sv
module dslope_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] shreg;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) shreg[0] <= 1'b0;
          else        shreg[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) shreg[i] <= 1'b0;
          else        shreg[i] <= shreg[i-1];
        end
      end
    end
  endgenerate

  assign q = shreg[STAGES-1];
endmodule

// File: rtl/dslope_stab.sv
module dslope_stab #(
  parameter int SETTLE_CYC = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  input  logic lvl,
  output logic settled
);
  localparam int ST_W = $clog2(SETTLE_CYC + 1);
  localparam logic [ST_W-1:0] LAST = ST_W'(SETTLE_CYC - 1);

  logic            lvl_d;
  logic [ST_W-1:0] cnt_q, cnt_d;
  logic            same;

  assign same    = (lvl == lvl_d);
  assign settled = en && same && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)                     cnt_d = '0;
    else if (en && !same)        cnt_d = '0;
    else if (en && cnt_q != LAST) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_d <= 1'b0;
      cnt_q <= '0;
    end else begin
      lvl_d <= lvl;
      cnt_q <= cnt_d;
    end
  end

  assert_settle_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !same) |=> (cnt_q == '0));
endmodule

// File: rtl/dslope_fsm.sv
module dslope_fsm
  import dslope_pkg::*;
#(
  parameter int CNT_W     = 24,
  parameter int AZ_CYC    = 13_200_000,
  parameter int INT_CYC   = 13_200_000,
  parameter int BLANK_CYC = 600
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       chan_req,
  input  logic [CNT_W-1:0] deint_max,
  input  logic             cmp_s,
  input  logic             settled,
  output logic             stab_clr,
  output logic             stab_en,
  output logic [1:0]       phase_ab,
  output logic [1:0]       chan_sel,
  output logic             busy,
  output logic             done,
  output logic             res_sign,
  output logic [CNT_W-1:0] res_mag,
  output logic             res_ovr
);
  localparam int MAX_PH = (AZ_CYC > INT_CYC) ? AZ_CYC : INT_CYC;
  localparam int PH_W   = $clog2(MAX_PH + 1);
  localparam logic [PH_W-1:0]  AZ_LAST  = PH_W'(AZ_CYC - 1);
  localparam logic [PH_W-1:0]  INT_LAST = PH_W'(INT_CYC - 1);
  localparam logic [CNT_W-1:0] BLANK    = CNT_W'(BLANK_CYC);

  seq_state_e       st_q, st_d;
  logic [PH_W-1:0]  ph_q;
  logic [CNT_W-1:0] mag_q;
  logic             pos_q, ovr_q, done_q;
  logic [1:0]       chan_q;

  logic accept, ph_clr, ph_en, hit, limit, deint_end, mag_en, pos_ld, ovr_set;

  assign accept    = (st_q == ST_IDLE) && start;
  assign hit       = (mag_q >= BLANK) && (cmp_s != pos_q);
  assign limit     = (mag_q == deint_max);
  assign deint_end = (st_q == ST_DEINT) && (hit || limit);

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE:  if (start)              st_d = ST_AZ;
      ST_AZ:    if (ph_q == AZ_LAST)    st_d = ST_INTG;
      ST_INTG:  if (ph_q == INT_LAST)   st_d = ST_DEINT;
      ST_DEINT: if (hit || limit)       st_d = ST_IZ;
      ST_IZ:    if (settled)            st_d = ST_IDLE;
      default:                          st_d = ST_IDLE;
    endcase
  end

  assign ph_clr   = (st_d != st_q);
  assign ph_en    = (st_q == ST_AZ) || (st_q == ST_INTG);
  assign mag_en   = (st_q == ST_DEINT) && !deint_end;
  assign pos_ld   = (st_q == ST_INTG) && (st_d == ST_DEINT);
  assign ovr_set  = (st_q == ST_DEINT) && limit && !hit;
  assign stab_clr = (st_q == ST_DEINT) && (st_d == ST_IZ);
  assign stab_en  = (st_q == ST_IZ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      ph_q   <= '0;
      mag_q  <= '0;
      pos_q  <= 1'b1;
      ovr_q  <= 1'b0;
      done_q <= 1'b0;
      chan_q <= 2'b00;
    end else begin
      st_q   <= st_d;
      done_q <= (st_q == ST_IZ) && settled;
      if (ph_clr)      ph_q <= '0;
      else if (ph_en)  ph_q <= ph_q + 1'b1;
      if (accept)      mag_q <= '0;
      else if (mag_en) mag_q <= mag_q + 1'b1;
      if (accept)       ovr_q <= 1'b0;
      else if (ovr_set) ovr_q <= 1'b1;
      if (pos_ld)      pos_q  <= cmp_s;
      if (accept)      chan_q <= chan_req;
    end
  end

  assign phase_ab = phase_code(st_q);
  assign chan_sel = chan_q;
  assign busy     = (st_q != ST_IDLE);
  assign done     = done_q;
  assign res_sign = ~pos_q;
  assign res_mag  = mag_q;
  assign res_ovr  = ovr_q;

  assert_order_az_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_ab == PH_AZ) |=> (phase_ab == PH_AZ || phase_ab == PH_INTG));
  assert_order_int_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_ab == PH_INTG) |=> (phase_ab == PH_INTG || phase_ab == PH_DEINT));
  assert_order_deint_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_ab == PH_DEINT) |=> (phase_ab == PH_DEINT || phase_ab == PH_IZ));
  assert_chan_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> $stable(chan_sel));
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_blank_floor_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !res_ovr) |-> (res_mag >= BLANK));
  assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(res_mag) && $stable(res_sign)));
endmodule

// File: rtl/dslope_seq.sv
module dslope_seq #(
  parameter int CNT_W      = 24,
  parameter int AZ_CYC     = 13_200_000,
  parameter int INT_CYC    = 13_200_000,
  parameter int BLANK_CYC  = 600,
  parameter int SETTLE_CYC = 64,
  parameter int SYNC_STG   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       chan_req,
  input  logic [CNT_W-1:0] deint_max,
  input  logic             cmp_async,
  output logic [1:0]       phase_ab,
  output logic [1:0]       chan_sel,
  output logic             busy,
  output logic             done,
  output logic             res_sign,
  output logic [CNT_W-1:0] res_mag,
  output logic             res_ovr
);
  logic cmp_s, settled, stab_clr, stab_en;

  dslope_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(cmp_async), .q(cmp_s)
  );

  dslope_stab #(.SETTLE_CYC(SETTLE_CYC)) u_stab (
    .clk(clk), .rst_n(rst_n), .clr(stab_clr), .en(stab_en),
    .lvl(cmp_s), .settled(settled)
  );

  dslope_fsm #(
    .CNT_W(CNT_W), .AZ_CYC(AZ_CYC), .INT_CYC(INT_CYC), .BLANK_CYC(BLANK_CYC)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .chan_req(chan_req),
    .deint_max(deint_max), .cmp_s(cmp_s), .settled(settled),
    .stab_clr(stab_clr), .stab_en(stab_en), .phase_ab(phase_ab),
    .chan_sel(chan_sel), .busy(busy), .done(done), .res_sign(res_sign),
    .res_mag(res_mag), .res_ovr(res_ovr)
  );
endmodule

// File: tb/dslope_seq_tb_top.sv
`timescale 1ns/1ps
module dslope_seq_tb_top;
  localparam int CNT_W  = 8;
  localparam int AZ     = 5;
  localparam int INTC   = 6;
  localparam int BLANK  = 4;
  localparam int SETTLE = 5;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [1:0]       chan_req = 2'b00;
  logic [CNT_W-1:0] deint_max = '0;
  logic             cmp_async = 1'b0;
  logic [1:0]       phase_ab, chan_sel;
  logic             busy, done, res_sign, res_ovr;
  logic [CNT_W-1:0] res_mag;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  dslope_seq #(
    .CNT_W(CNT_W), .AZ_CYC(AZ), .INT_CYC(INTC), .BLANK_CYC(BLANK),
    .SETTLE_CYC(SETTLE), .SYNC_STG(2)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .chan_req(chan_req),
    .deint_max(deint_max), .cmp_async(cmp_async), .phase_ab(phase_ab),
    .chan_sel(chan_sel), .busy(busy), .done(done), .res_sign(res_sign),
    .res_mag(res_mag), .res_ovr(res_ovr)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_conv(input int pos, input int k, input int dmax,
                          input int ch, input int noise, input int g_in,
                          input int bstart);
    int m, ovr, gr, g, izexp, n;
    m = (k + 2 > BLANK) ? k + 2 : BLANK;
    ovr = 0;
    if (m > dmax) begin m = dmax; ovr = 1; end
    g = g_in;
    if (k <= m && (k - m - 1) >= -2) begin
      gr = k - m - 1; izexp = gr + 3 + SETTLE; g = -1;
    end else if (g >= 0) izexp = g + 3 + SETTLE;
    else izexp = SETTLE;

    @(negedge clk);
    chan_req = ch[1:0]; deint_max = dmax[CNT_W-1:0]; start = 1'b1;
    @(negedge clk);
    start = 1'b0; chan_req = ~ch[1:0];
    n = 0;
    while (phase_ab == 2'b01 && n < 1000) begin
      n++; if (noise != 0) cmp_async = ~cmp_async; @(negedge clk);
    end
    check("R1 auto-zero length", n, AZ);
    n = 0;
    while (phase_ab == 2'b10 && n < 1000) begin
      if (n == 0) check("R3 channel held", int'(chan_sel), ch);
      cmp_async = pos[0];
      start = (bstart != 0 && n == 2);
      if (n == 3) chan_req = 2'(ch + 1);
      n++; @(negedge clk);
    end
    start = 1'b0;
    check("R1 integrate length", n, INTC);
    n = 0;
    while (phase_ab == 2'b11 && n < 1000) begin
      if (n == k) cmp_async = ~pos[0];
      n++; @(negedge clk);
    end
    check("R8 deintegrate length", n, m + 1);
    n = 0;
    while (phase_ab == 2'b00 && busy && n < 1000) begin
      if (n == g) cmp_async = ~cmp_async;
      n++; @(negedge clk);
    end
    check("R9 integrator-zero length", n, izexp);
    check("R10 done pulse high", int'(done), 1);
    check("R5 sign", int'(res_sign), 1 - pos);
    if (noise != 0) check("R4 sign with auto-zero noise", int'(res_sign), 1 - pos);
    check(ovr != 0 ? "R8 overrange magnitude" : "R6 magnitude", int'(res_mag), m);
    check("R8 overrange flag", int'(res_ovr), ovr);
    if (ovr == 0) check("R7 blank floor", int'(res_mag >= BLANK), 1);
    check("R3 channel after done", int'(chan_sel), ch);
    @(negedge clk);
    check("R10 done low after one cycle", int'(done), 0);
    check("R2 idle after conversion", int'(busy), 0);
    @(negedge clk);
    check("R10 magnitude held", int'(res_mag), m);
    check("R1 idle phase code", int'(phase_ab), 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check("R2 reset busy", int'(busy), 0);
    check("R2 reset done", int'(done), 0);
    check("R2 reset phase", int'(phase_ab), 0);
    check("R2 reset magnitude", int'(res_mag), 0);
    check("R2 reset overrange", int'(res_ovr), 0);
    check("R2 reset channel", int'(chan_sel), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    for (int pos = 0; pos < 2; pos++)
      for (int di = 0; di < 3; di++)
        for (int k = 0; k < 13; k++) begin
          int dm;
          dm = (di == 0) ? 6 : (di == 1) ? 10 : 255;
          run_conv(pos, k, dm, k % 4, k % 2, (pos == 1 && k < 3) ? k : -1, 0);
        end
    run_conv(1, 7, 255, 2, 1, -1, 1);
    run_conv(0, 3, 255, 1, 0, 2, 1);
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL R2 watchdog: actual=timeout expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule